// File: doc/BRIEF.md
# Tick Timer with Mode Register

This block is a 32-bit tick timer that sits beside a small processor core. Software reaches it through the core's special-purpose-register port. The address is a group number shifted left by 11 plus a register number within the group. The timer occupies group 10 and exposes two registers. The control register holds a 28-bit period, a pending flag, an interrupt enable and a two-bit operating mode. The count register holds the free-running 32-bit counter.

While the timer runs, the counter advances by one on every clock. When the low 28 counter bits equal the period, a match occurs. Depending on the mode, a match clears the counter, freezes it, or lets it carry on. A match with the enable set raises the pending flag, and the interrupt line to the core is the pending flag gated by the enable.

Counting starts and stops only when a control write actually changes the mode field. Rewriting the current mode leaves the run state alone. In a control write, a one in the pending position preserves the stored flag. A zero in that position clears it.

Top module: `tick_timer`

## Requirements
- R1: After reset the control register and the count register both read as zero, the timer is stopped and `timer_irq` is low.
- R2: The control register answers at address 0x5000 (group 10, number 0) and the count register at 0x5001 (group 10, number 1). Any other address reads as zero, and a write to it changes neither register.
- R3: The control register layout is period in bits 27:0, pending in bit 28, interrupt enable in bit 29 and mode in bits 31:30. The mode codes are 00 off, 01 restart, 10 one-shot and 11 continuous. A read returns all four fields in these positions.
- R4: While the timer runs and no match or count write occurs, the counter increases by exactly one per clock.
- R5: The run state changes only on a control write whose mode differs from the stored mode. Writing off stops counting, and writing any other code starts it. Rewriting the stored mode leaves the run state unchanged.
- R6: A control write with bit 28 set keeps the stored pending flag, and the period, enable and mode take the written values.
- R7: A control write with bit 28 clear clears the pending flag, so `timer_irq` is low from the following cycle.
- R8: A write to the count register loads the counter at the next edge, overriding increment and match effects. The match test then uses the loaded value.
- R9: A match occurs when the timer runs and counter bits 27:0 equal the period. On a match with the enable set, the pending flag becomes one at the next edge.
- R10: In restart mode a match sets the counter to zero at the next edge.
- R11: In one-shot mode a match stops counting, and the counter holds the matched value.
- R12: In continuous mode a match does not disturb counting; the counter keeps incrementing.
- R13: `timer_irq` equals pending AND interrupt enable at all times.
- R14: A read of the count register returns the counter value of the current cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spr_addr | input | 16 | Register address, group in bits 15:11 |
| spr_we | input | 1 | Write strobe for the addressed register |
| spr_wdata | input | 32 | Write data |
| spr_rdata | output | 32 | Read data for the addressed register, combinational |
| timer_irq | output | 1 | Timer interrupt request to the core |

## Verification
Read data is combinational from the registered state, so a read reflects the state in the same cycle the address is presented. A write, a counter step, a match effect or a pending update appears one edge later. `timer_irq` carries no extra register beyond the pending flag, so it also moves one edge after the match or clearing write that caused it. The bench drives each cycle's inputs just after the falling edge and samples read data and the interrupt 1 ns later, before the next rising edge. It then advances its reference model exactly once, so every comparison lines up with the cycle in which the requirement says the result is due.

// File: rtl/tt_pkg.sv
package tt_pkg;
    localparam int DATA_W     = 32;
    localparam int PERIOD_W   = 28;
    localparam int PEND_BIT   = PERIOD_W;
    localparam int IE_BIT     = PERIOD_W + 1;
    localparam int MODE_LSB   = PERIOD_W + 2;
    localparam int MODE_W     = DATA_W - MODE_LSB;
    localparam int ADDR_W     = 16;
    localparam int GRP_SHIFT  = 11;
    localparam int TIMER_GRP  = 10;
    localparam int CTRL_NUM   = 0;
    localparam int COUNT_NUM  = 1;

    typedef enum logic [MODE_W-1:0] {
        TT_OFF     = 2'd0,
        TT_RESTART = 2'd1,
        TT_ONESHOT = 2'd2,
        TT_CONT    = 2'd3
    } tt_mode_e;

    typedef struct packed {
        tt_mode_e            mode;
        logic                ie;
        logic                pend;
        logic [PERIOD_W-1:0] period;
        logic [DATA_W-1:0]   cnt;
        logic                run;
    } tt_state_t;
endpackage

// File: rtl/tt_decode.sv
module tt_decode
    import tt_pkg::*;
#(
    parameter int GROUP = TIMER_GRP
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output logic              ctrl_sel,
    output logic              cnt_sel,
    output logic              ctrl_we,
    output logic              cnt_we
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR  = ADDR_W'((GROUP << GRP_SHIFT) + CTRL_NUM);
    localparam logic [ADDR_W-1:0] COUNT_ADDR = ADDR_W'((GROUP << GRP_SHIFT) + COUNT_NUM);

    always_comb begin
        ctrl_sel = (addr == CTRL_ADDR);
        cnt_sel  = (addr == COUNT_ADDR);
        ctrl_we  = we && ctrl_sel;
        cnt_we   = we && cnt_sel;
    end
endmodule

// File: rtl/tt_engine.sv
module tt_engine
    import tt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic              cnt_we,
    input  logic [DATA_W-1:0] wdata,
    output tt_state_t         st_q,
    output logic              match
);
    tt_state_t st_d;
    tt_mode_e  wr_mode;

    always_comb begin
        st_d    = st_q;
        wr_mode = tt_mode_e'(wdata[DATA_W-1:MODE_LSB]);
        match   = st_q.run && (st_q.cnt[PERIOD_W-1:0] == st_q.period);

        if (st_q.run) begin
            st_d.cnt = st_q.cnt + DATA_W'(1);
            if (match) begin
                unique case (st_q.mode)
                    TT_RESTART: st_d.cnt = '0;
                    TT_ONESHOT: begin
                        st_d.cnt = st_q.cnt;
                        st_d.run = 1'b0;
                    end
                    default: ;
                endcase
            end
        end

        if (match && st_q.ie) begin
            st_d.pend = 1'b1;
        end

        if (ctrl_we) begin
            st_d.mode   = wr_mode;
            st_d.ie     = wdata[IE_BIT];
            st_d.period = wdata[PERIOD_W-1:0];
            if (!wdata[PEND_BIT]) begin
                st_d.pend = 1'b0;
            end
            if (wr_mode != st_q.mode) begin
                st_d.run = (wr_mode != TT_OFF);
            end
        end

        if (cnt_we) begin
            st_d.cnt = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && !match && !cnt_we) |=> st_q.cnt == $past(st_q.cnt) + DATA_W'(1));

    p_hold_stopped_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run && !cnt_we && !ctrl_we) |=> $stable(st_q.cnt));

    p_start_on_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && wr_mode != st_q.mode && wr_mode != TT_OFF) |=> st_q.run);

    p_pend_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && wdata[PEND_BIT] && !(match && st_q.ie)) |=> st_q.pend == $past(st_q.pend));

    p_pend_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && !wdata[PEND_BIT]) |=> !st_q.pend);

    p_pend_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (match && st_q.ie && !ctrl_we) |=> st_q.pend);

    p_restart_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (match && st_q.mode == TT_RESTART && !cnt_we) |=> st_q.cnt == '0);

    p_oneshot_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (match && st_q.mode == TT_ONESHOT && !ctrl_we) |=> !st_q.run);
endmodule

// File: rtl/tt_readback.sv
module tt_readback
    import tt_pkg::*;
(
    input  logic              ctrl_sel,
    input  logic              cnt_sel,
    input  tt_state_t         st,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (ctrl_sel) begin
            rdata = {st.mode, st.ie, st.pend, st.period};
        end else if (cnt_sel) begin
            rdata = st.cnt;
        end
    end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tt_pkg::*;
#(
    parameter int GROUP = TIMER_GRP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] spr_addr,
    input  logic              spr_we,
    input  logic [DATA_W-1:0] spr_wdata,
    output logic [DATA_W-1:0] spr_rdata,
    output logic              timer_irq
);
    logic      ctrl_sel;
    logic      cnt_sel;
    logic      ctrl_we;
    logic      cnt_we;
    logic      match;
    tt_state_t st;

    tt_decode #(.GROUP(GROUP)) u_decode (
        .addr     (spr_addr),
        .we       (spr_we),
        .ctrl_sel (ctrl_sel),
        .cnt_sel  (cnt_sel),
        .ctrl_we  (ctrl_we),
        .cnt_we   (cnt_we)
    );

    tt_engine u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_we (ctrl_we),
        .cnt_we  (cnt_we),
        .wdata   (spr_wdata),
        .st_q    (st),
        .match   (match)
    );

    tt_readback u_readback (
        .ctrl_sel (ctrl_sel),
        .cnt_sel  (cnt_sel),
        .st       (st),
        .rdata    (spr_rdata)
    );

    assign timer_irq = st.pend && st.ie;

    p_sel_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctrl_sel, cnt_sel}));

    p_irq_needs_pending_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && !spr_wdata[PEND_BIT]) |=> !timer_irq);

    p_run_implies_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st.run |-> st.mode != TT_OFF);
endmodule

// File: tb/sim_tick_timer.sv
`timescale 1ns/1ps
module sim_tick_timer;
    localparam logic [15:0] A_CTRL = 16'h5000;
    localparam logic [15:0] A_CNT  = 16'h5001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] spr_addr = '0;
    logic        spr_we = 1'b0;
    logic [31:0] spr_wdata = '0;
    logic [31:0] spr_rdata;
    logic        timer_irq;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [1:0]  m_mode;
    logic        m_ie, m_pend, m_run;
    logic [27:0] m_per;
    logic [31:0] m_cnt;

    always #4 clk = ~clk;

    tick_timer u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .spr_addr  (spr_addr),
        .spr_we    (spr_we),
        .spr_wdata (spr_wdata),
        .spr_rdata (spr_rdata),
        .timer_irq (timer_irq)
    );

    function automatic logic [31:0] ctrl_word(logic [1:0] md, logic ie, logic pd, logic [27:0] per);
        return {md, ie, pd, per};
    endfunction

    function automatic logic [31:0] model_read(logic [15:0] a);
        if (a == A_CTRL) return {m_mode, m_ie, m_pend, m_per};
        if (a == A_CNT)  return m_cnt;
        return 32'd0;
    endfunction

    task automatic model_step(logic we, logic [15:0] a, logic [31:0] d);
        logic        hit;
        logic [1:0]  n_mode;
        logic        n_ie, n_pend, n_run;
        logic [27:0] n_per;
        logic [31:0] n_cnt;
        hit = m_run && (m_cnt[27:0] == m_per);
        n_mode = m_mode; n_ie = m_ie; n_pend = m_pend; n_run = m_run;
        n_per = m_per; n_cnt = m_cnt;
        if (m_run) begin
            n_cnt = m_cnt + 32'd1;
            if (hit && m_mode == 2'd1) n_cnt = 32'd0;
            if (hit && m_mode == 2'd2) begin n_cnt = m_cnt; n_run = 1'b0; end
        end
        if (hit && m_ie) n_pend = 1'b1;
        if (we && a == A_CTRL) begin
            n_mode = d[31:30]; n_ie = d[29]; n_per = d[27:0];
            if (!d[28]) n_pend = 1'b0;
            if (d[31:30] != m_mode) n_run = (d[31:30] != 2'd0);
        end
        if (we && a == A_CNT) n_cnt = d;
        m_mode = n_mode; m_ie = n_ie; m_pend = n_pend; m_run = n_run;
        m_per = n_per; m_cnt = n_cnt;
    endtask

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    // One clock cycle: drive, sample the current state, advance the model.
    task automatic cyc(string req, logic we, logic [15:0] a, logic [31:0] d);
        @(negedge clk);
        spr_we = we; spr_addr = a; spr_wdata = d;
        #1;
        check(req, spr_rdata, model_read(a));
        check("R13", {31'd0, timer_irq}, {31'd0, m_pend & m_ie});
        model_step(we, a, d);
    endtask

    task automatic idle(string req, int n, logic [15:0] a);
        for (int i = 0; i < n; i++) cyc(req, 1'b0, a, 32'd0);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1c3d));
        m_mode = 0; m_ie = 0; m_pend = 0; m_run = 0; m_per = 0; m_cnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        cyc("R1", 1'b0, A_CTRL, 0);
        check("R1", spr_rdata, 32'd0);
        cyc("R1", 1'b0, A_CNT, 0);
        check("R1", spr_rdata, 32'd0);
        idle("R1", 3, A_CNT);

        // R4 continuous counting, no interrupt enable, large period
        cyc("R3", 1'b1, A_CTRL, ctrl_word(2'd3, 1'b0, 1'b0, 28'hFFF_FFFF));
        idle("R4", 10, A_CNT);
        check("R4", spr_rdata, 32'd9);

        // R8 load counter; R14 reads follow
        cyc("R8", 1'b1, A_CNT, 32'd100);
        idle("R14", 4, A_CNT);
        check("R14", spr_rdata, 32'd103);

        // R5 rewriting the same mode keeps it running
        cyc("R5", 1'b1, A_CTRL, ctrl_word(2'd3, 1'b0, 1'b0, 28'hFFF_FFF0));
        idle("R5", 3, A_CNT);
        // R5 stop, then rewrite off: stays stopped
        cyc("R5", 1'b1, A_CTRL, ctrl_word(2'd0, 1'b0, 1'b0, 28'd0));
        idle("R5", 3, A_CNT);
        cyc("R5", 1'b1, A_CTRL, ctrl_word(2'd0, 1'b1, 1'b1, 28'd7));
        idle("R5", 3, A_CNT);
        check("R5", spr_rdata, m_cnt);

        // R10 restart mode with interrupt
        cyc("R8", 1'b1, A_CNT, 32'd0);
        cyc("R10", 1'b1, A_CTRL, ctrl_word(2'd1, 1'b1, 1'b0, 28'd4));
        idle("R10", 14, A_CNT);
        idle("R9", 2, A_CTRL);
        check("R9", {31'd0, timer_irq}, 32'd1);

        // R6 pending kept by writing one, R7 cleared by zero
        cyc("R6", 1'b1, A_CTRL, ctrl_word(2'd1, 1'b1, 1'b1, 28'd4));
        idle("R6", 1, A_CTRL);
        cyc("R7", 1'b1, A_CTRL, ctrl_word(2'd1, 1'b1, 1'b0, 28'd1000));
        idle("R7", 2, A_CTRL);
        check("R7", {31'd0, timer_irq}, 32'd0);

        // R12 continuous: match sets pending, counter goes past period
        cyc("R8", 1'b1, A_CNT, 32'd10);
        cyc("R12", 1'b1, A_CTRL, ctrl_word(2'd3, 1'b1, 1'b0, 28'd14));
        idle("R12", 10, A_CNT);
        check("R12", spr_rdata, 32'd20);

        // R11 one-shot stops at period; same-mode rewrite does not restart
        cyc("R8", 1'b1, A_CNT, 32'd0);
        cyc("R11", 1'b1, A_CTRL, ctrl_word(2'd2, 1'b0, 1'b0, 28'd5));
        idle("R11", 10, A_CNT);
        check("R11", spr_rdata, 32'd5);
        cyc("R5", 1'b1, A_CTRL, ctrl_word(2'd2, 1'b0, 1'b0, 28'd9));
        idle("R5", 4, A_CNT);
        check("R5", spr_rdata, 32'd5);

        // R2 unmapped addresses: read zero, writes ignored
        cyc("R2", 1'b1, 16'h5002, 32'hFFFF_FFFF);
        cyc("R2", 1'b1, 16'h4800, 32'hFFFF_FFFF);
        cyc("R2", 1'b1, 16'h0001, 32'h1234_5678);
        idle("R2", 2, A_CTRL);
        check("R2", spr_rdata, ctrl_word(2'd2, 1'b0, 1'b0, 28'd9));

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            int unsigned r;
            logic [15:0] a;
            logic [31:0] d;
            logic we;
            r = $urandom % 100;
            we = (r < 15);
            case ($urandom % 5)
                0, 1: a = A_CTRL;
                2, 3: a = A_CNT;
                default: a = 16'h5000 + 16'($urandom % 8);
            endcase
            if (a == A_CTRL) d = ctrl_word(2'($urandom), 1'($urandom), 1'($urandom), 28'($urandom % 12));
            else             d = 32'($urandom % 16);
            cyc("R9", we, a, d);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule